// File: doc/BRIEF.md
# Binary Fat-Tree Router Node with One Uplink

This block is one switching node of a butterfly fat-tree overlay network. It has two child-facing duplex links (left and right) and one parent-facing duplex link. Each link carries single-flit packets: the flit holds a destination client address in its upper bits and a data payload in its lower bits. A flit from a child link either climbs to the parent or turns across to the other child link. A flit from the parent descends to the left or right child, chosen by one address bit.

Each output is a registered stage with its own two-way round-robin arbiter. There is no queue. A flit that loses arbitration, or that finds its output stalled, is parked in a one-entry shadow register on its input. While that register is full the input raises backpressure. The parameters `LEVEL` and `POS` place the node in the tree. The node's subtree is the set of addresses whose bits above bit `LEVEL` equal `POS`. Bit `LEVEL` selects the child side within that subtree.

Top module: `bft_bin_switch`

## Requirements
- R1: While `rst` is high at a clock edge, all three output valids and all three input backpressure signals are low after that edge.
- R2: A flit from the left or right input whose address, shifted right by `LEVEL+1`, differs from `POS` leaves on the uphill output.
- R3: A flit from the left input whose address lies in the subtree leaves on the right output. A flit from the right input whose address lies in the subtree leaves on the left output.
- R4: A flit from the uphill input leaves on the left output when address bit `LEVEL` is 0, and on the right output when it is 1.
- R5: With no contention and no stall, a flit accepted at clock edge k is presented on its output after edge k, which is one cycle of latency.
- R6: While an output's valid and its `*_out_bp` are both high, the output's valid and flit are held unchanged on the next cycle.
- R7: A flit that cannot take its output in the cycle it arrives is parked. The input's backpressure is high exactly while the parked flit waits. Parked flits leave before later flits from the same input.
- R8: When two inputs keep contending for one output, the grants alternate between them.
- R9: An input valid asserted while that input's backpressure is high is ignored. The parked flit is not overwritten.
- R10: A flit leaves an output only when that output's backpressure is low. Every accepted flit emerges exactly once, and no other flit emerges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lft_in_vld | input | 1 | Left child flit valid |
| lft_in_flit | input | ADDR_W+DATA_W | Left child flit, address in the top bits |
| lft_in_bp | output | 1 | Backpressure to the left child |
| lft_out_vld | output | 1 | Flit valid toward the left child |
| lft_out_flit | output | ADDR_W+DATA_W | Flit toward the left child |
| lft_out_bp | input | 1 | Backpressure from the left child |
| rgt_in_vld | input | 1 | Right child flit valid |
| rgt_in_flit | input | ADDR_W+DATA_W | Right child flit |
| rgt_in_bp | output | 1 | Backpressure to the right child |
| rgt_out_vld | output | 1 | Flit valid toward the right child |
| rgt_out_flit | output | ADDR_W+DATA_W | Flit toward the right child |
| rgt_out_bp | input | 1 | Backpressure from the right child |
| up_in_vld | input | 1 | Parent flit valid |
| up_in_flit | input | ADDR_W+DATA_W | Parent flit |
| up_in_bp | output | 1 | Backpressure to the parent |
| up_out_vld | output | 1 | Flit valid toward the parent |
| up_out_flit | output | ADDR_W+DATA_W | Flit toward the parent |
| up_out_bp | input | 1 | Backpressure from the parent |

## Verification
The bench builds the node with `LEVEL=1`, `POS=3`, a 6-bit address and a 32-bit payload. This places it one level above the leaves, so the subtree is addresses 12 to 15 and address bit 1 picks the side. Random addresses therefore exercise both the climb and the turn decisions, and the descent bit is not simply the lowest address bit. Random stalls on all three outputs fill the shadow registers and exercise the ordering of parked flits.

// File: rtl/bft_bin_switch.sv
module bft_bin_switch #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LEVEL  = 0,
  parameter int POS    = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lft_in_vld,
  input  logic [ADDR_W+DATA_W-1:0] lft_in_flit,
  output logic                     lft_in_bp,
  output logic                     lft_out_vld,
  output logic [ADDR_W+DATA_W-1:0] lft_out_flit,
  input  logic                     lft_out_bp,
  input  logic                     rgt_in_vld,
  input  logic [ADDR_W+DATA_W-1:0] rgt_in_flit,
  output logic                     rgt_in_bp,
  output logic                     rgt_out_vld,
  output logic [ADDR_W+DATA_W-1:0] rgt_out_flit,
  input  logic                     rgt_out_bp,
  input  logic                     up_in_vld,
  input  logic [ADDR_W+DATA_W-1:0] up_in_flit,
  output logic                     up_in_bp,
  output logic                     up_out_vld,
  output logic [ADDR_W+DATA_W-1:0] up_out_flit,
  input  logic                     up_out_bp
);
  localparam int FW = ADDR_W + DATA_W;

  // port index: 0 left, 1 right, 2 up
  logic [2:0]    in_vld_a, out_bp_a, out_free;
  logic [FW-1:0] in_flit_a [3];
  logic [2:0]    sh_vld, out_vld_q, rr_q;
  logic [FW-1:0] sh_q [3];
  logic [FW-1:0] out_q [3];
  logic [2:0]    head_v;
  logic [FW-1:0] head [3];
  logic [1:0]    dst [3];
  logic [2:0]    gnt_in, win_v, win_hi;
  logic [1:0]    win_src [3];

  assign in_vld_a     = {up_in_vld, rgt_in_vld, lft_in_vld};
  assign out_bp_a     = {up_out_bp, rgt_out_bp, lft_out_bp};
  assign in_flit_a[0] = lft_in_flit;
  assign in_flit_a[1] = rgt_in_flit;
  assign in_flit_a[2] = up_in_flit;
  assign out_free     = ~(out_vld_q & out_bp_a);

  assign lft_in_bp    = sh_vld[0];
  assign rgt_in_bp    = sh_vld[1];
  assign up_in_bp     = sh_vld[2];
  assign lft_out_vld  = out_vld_q[0];
  assign rgt_out_vld  = out_vld_q[1];
  assign up_out_vld   = out_vld_q[2];
  assign lft_out_flit = out_q[0];
  assign rgt_out_flit = out_q[1];
  assign up_out_flit  = out_q[2];

  function automatic logic [1:0] route(input int src, input logic [FW-1:0] f);
    logic [ADDR_W-1:0] a;
    logic in_sub;
    a = f[FW-1 -: ADDR_W];
    in_sub = ((a >> (LEVEL + 1)) == ADDR_W'(POS));
    if (src == 2)   return a[LEVEL] ? 2'd1 : 2'd0;
    else if (in_sub) return (src == 0) ? 2'd1 : 2'd0;
    else            return 2'd2;
  endfunction

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      head_v[i] = sh_vld[i] | in_vld_a[i];
      head[i]   = sh_vld[i] ? sh_q[i] : in_flit_a[i];
      dst[i]    = route(i, head[i]);
    end
  end

  always_comb begin
    int s0, s1;
    logic r0, r1;
    gnt_in = '0;
    win_v  = '0;
    win_hi = '0;
    for (int o = 0; o < 3; o++) begin
      s0 = (o == 0) ? 1 : 0;
      s1 = (o == 2) ? 1 : 2;
      r0 = head_v[s0] && (dst[s0] == 2'(o));
      r1 = head_v[s1] && (dst[s1] == 2'(o));
      win_hi[o]  = r1 && (!r0 || rr_q[o]);
      win_src[o] = win_hi[o] ? 2'(s1) : 2'(s0);
      win_v[o]   = out_free[o] && (r0 || r1);
      if (win_v[o]) gnt_in[win_src[o]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_vld    <= '0;
      out_vld_q <= '0;
      rr_q      <= '0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (gnt_in[k]) sh_vld[k] <= 1'b0;
        else if (in_vld_a[k] && !sh_vld[k]) begin
          sh_vld[k] <= 1'b1;
          sh_q[k]   <= in_flit_a[k];
        end
        if (win_v[k]) begin
          out_vld_q[k] <= 1'b1;
          out_q[k]     <= head[win_src[k]];
          rr_q[k]      <= ~win_hi[k];
        end else if (out_free[k]) out_vld_q[k] <= 1'b0;
      end
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (out_vld_q == 3'b0 && sh_vld == 3'b0));

  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld_q[g] && out_bp_a[g] |=> out_vld_q[g] && $stable(out_q[g]));
    // R10
    out_leave_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(out_vld_q[g]) |-> $past(!out_bp_a[g]));
    // R7
    park_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sh_vld[g]) |-> $past(in_vld_a[g]));
  end
endmodule

// File: tb/bft_bin_switch_bench.sv
module bft_bin_switch_bench;
  localparam int DW = 32, AW = 6, FW = AW + DW, LV = 1, PS = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst = 1'b1;

  logic          ivld [3];
  logic [FW-1:0] iflit [3];
  logic          ibp [3];
  logic          ovld [3];
  logic [FW-1:0] oflit [3];
  logic          obp [3];

  bft_bin_switch #(.DATA_W(DW), .ADDR_W(AW), .LEVEL(LV), .POS(PS)) u_bft_bin_switch (
    .clk(clk), .rst(rst),
    .lft_in_vld(ivld[0]), .lft_in_flit(iflit[0]), .lft_in_bp(ibp[0]),
    .lft_out_vld(ovld[0]), .lft_out_flit(oflit[0]), .lft_out_bp(obp[0]),
    .rgt_in_vld(ivld[1]), .rgt_in_flit(iflit[1]), .rgt_in_bp(ibp[1]),
    .rgt_out_vld(ovld[1]), .rgt_out_flit(oflit[1]), .rgt_out_bp(obp[1]),
    .up_in_vld(ivld[2]), .up_in_flit(iflit[2]), .up_in_bp(ibp[2]),
    .up_out_vld(ovld[2]), .up_out_flit(oflit[2]), .up_out_bp(obp[2])
  );

  int checks = 0, errors = 0;
  logic [FW-1:0] expq [3][$];
  bit rand_bp = 0, fair_on = 0;
  int fcnt [3];
  int fn = 0;
  int seqn [3];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_out(int p, logic [AW-1:0] a);
    bit outside;
    outside = ((a >> 2) != 6'(PS));
    if (p == 2) return a[LV] ? 1 : 0;
    if (outside) return 2;
    return (p == 0) ? 1 : 0;
  endfunction

  task automatic send(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    while (ibp[p]) @(negedge clk);
    ivld[p]  = 1'b1;
    iflit[p] = {a, d};
    @(posedge clk);
    expq[exp_out(p, a)].push_back({a, d});
    #1 ivld[p] = 1'b0;
  endtask

  function automatic logic [DW-1:0] mk(int p);
    logic [DW-1:0] d;
    d = {2'(p), 30'(seqn[p])};
    seqn[p]++;
    return d;
  endfunction

  task automatic stream(int p, int n, bit rnd, logic [AW-1:0] fixa);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = rnd ? AW'($urandom_range(0, 63)) : fixa;
      send(p, a, mk(p));
      if (rnd) repeat ($urandom_range(0, 2)) @(posedge clk);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rand_bp) for (int o = 0; o < 3; o++) obp[o] = ($urandom_range(0, 9) < 3);
  end

  // scoreboard monitor: every negedge with valid and no stall is one flit leaving
  always @(negedge clk) begin
    if (!rst) begin
      for (int o = 0; o < 3; o++) begin
        if (ovld[o] && !obp[o]) begin
          int s, j;
          bit found;
          string tag;
          s = int'(oflit[o][DW-1 -: 2]);
          tag = (s == 2) ? "R4" : ((o == 2) ? "R2" : "R3");
          found = 0;
          j = 0;
          for (int k = 0; k < expq[o].size(); k++)
            if (!found && int'(expq[o][k][DW-1 -: 2]) == s) begin j = k; found = 1; end
          if (!found) chk(0, {tag, "/R10 unexpected flit"}, longint'(oflit[o]), 0);
          else begin
            chk(expq[o][j] == oflit[o], {tag, "/R7 flit order"}, longint'(oflit[o]), longint'(expq[o][j]));
            expq[o].delete(j);
          end
          if (fair_on && o == 2 && fn < 20) begin
            fcnt[s]++;
            fn++;
          end
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] da, db;
    for (int o = 0; o < 3; o++) begin
      ivld[o] = 0; iflit[o] = '0; obp[o] = 0; fcnt[o] = 0; seqn[o] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int o = 0; o < 3; o++) begin
      chk(ovld[o] == 0, "R1 out valid in reset", ovld[o], 0);
      chk(ibp[o] == 0, "R1 backpressure in reset", ibp[o], 0);
    end
    rst = 1'b0;

    // R5 single hop latency, R2 climb
    da = mk(0);
    send(0, 6'd40, da);
    @(negedge clk);
    chk(ovld[2] == 1, "R5 uphill valid after one edge", ovld[2], 1);
    chk(oflit[2] == {6'd40, da}, "R5 uphill flit", longint'(oflit[2]), longint'({6'd40, da}));

    // R3 turns, R4 descent
    send(0, 6'd13, mk(0));
    send(1, 6'd12, mk(1));
    send(2, 6'd14, mk(2));
    send(2, 6'd12, mk(2));
    send(1, 6'd3, mk(1));
    send(2, 6'd50, mk(2));
    repeat (6) @(posedge clk);

    // R7 park, R6 hold, R9 ignore
    @(negedge clk);
    obp[2] = 1'b1;
    da = mk(0);
    db = mk(0);
    send(0, 6'd40, da);
    send(0, 6'd41, db);
    @(negedge clk);
    chk(ibp[0] == 1, "R7 backpressure while parked", ibp[0], 1);
    chk(ovld[2] == 1 && oflit[2] == {6'd40, da}, "R6 stalled output holds", longint'(oflit[2]), longint'({6'd40, da}));
    ivld[0]  = 1'b1;
    iflit[0] = {6'd42, 2'd0, 30'h3FFF_FFFF};
    repeat (2) @(negedge clk);
    chk(oflit[2] == {6'd40, da}, "R6 still held", longint'(oflit[2]), longint'({6'd40, da}));
    chk(ibp[0] == 1, "R9 input still blocked", ibp[0], 1);
    ivld[0] = 1'b0;
    obp[2]  = 1'b0;
    repeat (2) @(negedge clk);
    chk(ibp[0] == 0, "R7 backpressure released", ibp[0], 0);
    repeat (4) @(posedge clk);

    // R8 fairness under sustained contention for the uphill output
    fair_on = 1;
    fork
      stream(0, 20, 0, 6'd33);
      stream(1, 20, 0, 6'd7);
    join
    repeat (6) @(posedge clk);
    fair_on = 0;
    chk(fn == 20, "R8 uphill outputs counted", fn, 20);
    chk((fcnt[0] - fcnt[1] <= 1) && (fcnt[1] - fcnt[0] <= 1), "R8 alternating grants",
        fcnt[0], fcnt[1]);

    // random traffic with random stalls
    rand_bp = 1;
    fork
      stream(0, 60, 1, 6'd0);
      stream(1, 60, 1, 6'd0);
      stream(2, 60, 1, 6'd0);
    join
    rand_bp = 0;
    @(posedge clk);
    #6;
    for (int o = 0; o < 3; o++) obp[o] = 0;
    for (int c = 0; c < 200; c++) begin
      if (expq[0].size() == 0 && expq[1].size() == 0 && expq[2].size() == 0) break;
      @(posedge clk);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int o = 0; o < 3; o++) begin
      chk(expq[o].size() == 0, "R10 every flit delivered", expq[o].size(), 0);
      chk(ovld[o] == 0, "R10 no extra flit", ovld[o], 0);
    end
    summary();
    $finish;
  end
endmodule